// File: doc/BRIEF.md
# Dual-Issue Pairing and Predecode Logic

This block decides, for an aligned pair of 32-bit instructions, whether both can go to execution in one cycle or must go one after the other. As a pair is offered for writing into the instruction store, a predecode function classifies each word and forms a 4-bit tag. The pair and its tag are then held in a single dispatch register. The dispatcher reads only the stored tag, never the opcodes, to steer each word to the integer port or the floating-point port and to raise the per-port valid signals.

Dual issue happens only when exactly one word of the pair is a floating-point computational operation. The other word (an integer operation, a branch or a floating-point load) takes the integer port in the same cycle. With such companions, a new floating-point calculation can start every cycle. A pair that does not qualify is split: the first word issues alone, and the second issues alone in the next cycle while fetch is held off. A downstream stall freezes the held pair and silences both ports.

Top module: `dual_issue_pair`

## Requirements
- R1: A word counts as FP computational when its opcode field [31:26] is 6'h13, or when the opcode is 6'h11 and field [25:21] is 5'h10 or 5'h11. Every other word is non-FP, including 6'h11 with any other [25:21] value and the FP load opcode 6'h31.
- R2: `fill_tag` is combinational from the offered pair. Bit 1 is set when word 0 is FP, bit 2 when word 1 is FP, and bit 0 (pairable) when exactly one of them is FP. Bit 3 is always 0.
- R3: A pairable pair issues in the first cycle after acceptance, with both valids high. The FP word appears on `fp_instr` and the other word on `int_instr`, whichever slot each came from.
- R4: A non-pairable pair issues word 0 alone in the first cycle after acceptance and word 1 alone in the next unstalled cycle. Each word goes to the FP port if it is FP and to the integer port otherwise, so two integer words never issue together.
- R5: While the first word of a split pair is issuing, `in_ready` is low, so no new pair is accepted.
- R6: While `stall` is high, both valids are low and the held pair and its issue phase are kept. The pair issues unchanged after the stall ends.
- R7: `in_ready` is high whenever the register is empty, or when the held pair finishes issuing this cycle without a stall. Pairable pairs can therefore be accepted and issued back to back at one per cycle.
- R8: After reset, both valids are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A pair is offered this cycle |
| in_instr0 | input | 32 | First (older) word of the pair |
| in_instr1 | input | 32 | Second word of the pair |
| in_ready | output | 1 | Pair accepted at this edge when in_valid is high |
| fill_tag | output | 4 | Predecode tag of the offered pair |
| stall | input | 1 | Downstream hold |
| int_valid | output | 1 | Integer port carries a word |
| int_instr | output | 32 | Word on the integer port |
| fp_valid | output | 1 | FP port carries a word |
| fp_instr | output | 32 | Word on the FP port |

## Verification
Within one cycle the block can predecode a new pair and accept it while it dispatches the previous pair. In the same cycle, a downstream stall can collide with the first half of a split pair. Random offers with random stall cycles provoke both overlaps, and directed cases add back-to-back pairable pairs and stalls placed inside a split. A bench model keeps the queue of expected issue beats for every accepted pair. Each cycle it judges the tag of the current offer, the expected `in_ready` (worked out from the number of beats still pending and the stall), and the valids and words on both ports against the head of that queue.

// File: rtl/dual_issue_pair.sv
module dual_issue_pair #(
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [IW-1:0] in_instr0,
  input  logic [IW-1:0] in_instr1,
  output logic          in_ready,
  output logic [3:0]    fill_tag,
  input  logic          stall,
  output logic          int_valid,
  output logic [IW-1:0] int_instr,
  output logic          fp_valid,
  output logic [IW-1:0] fp_instr
);
  localparam int OPW = 6;
  localparam int FMW = 5;

  function automatic logic is_fp(input logic [IW-1:0] w);
    logic [OPW-1:0] op;
    logic [FMW-1:0] fmt;
    op  = w[IW-1 -: OPW];
    fmt = w[IW-1-OPW -: FMW];
    return (op == 6'h13) || (op == 6'h11 && (fmt == 5'h10 || fmt == 5'h11));
  endfunction

  logic          fp0, fp1;
  logic          pd_valid, second;
  logic [IW-1:0] pd_i0, pd_i1;
  logic [2:0]    pd_tag;
  logic          go, consume, cur_fp;
  logic [IW-1:0] cur_i;

  assign fp0      = is_fp(in_instr0);
  assign fp1      = is_fp(in_instr1);
  assign fill_tag = {1'b0, fp1, fp0, fp0 ^ fp1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd_valid <= 1'b0;
      second   <= 1'b0;
      pd_i0    <= '0;
      pd_i1    <= '0;
      pd_tag   <= '0;
    end else if (in_ready) begin
      pd_valid <= in_valid;
      second   <= 1'b0;
      if (in_valid) begin
        pd_i0  <= in_instr0;
        pd_i1  <= in_instr1;
        pd_tag <= fill_tag[2:0];
      end
    end else if (!stall) begin
      second <= 1'b1;
    end
  end

  assign go       = pd_valid && !stall;
  assign consume  = go && (pd_tag[0] || second);
  assign in_ready = !pd_valid || consume;

  assign cur_i  = second ? pd_i1 : pd_i0;
  assign cur_fp = second ? pd_tag[2] : pd_tag[1];

  assign fp_instr  = pd_tag[0] ? (pd_tag[1] ? pd_i0 : pd_i1) : cur_i;
  assign int_instr = pd_tag[0] ? (pd_tag[1] ? pd_i1 : pd_i0) : cur_i;
  assign fp_valid  = go && (pd_tag[0] || cur_fp);
  assign int_valid = go && (pd_tag[0] || !cur_fp);
endmodule

// File: rtl/dual_issue_pair_chk.sv
module dual_issue_pair_chk #(
  parameter int IW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [IW-1:0] in_instr0,
  input logic [IW-1:0] in_instr1,
  input logic          in_ready,
  input logic [3:0]    fill_tag,
  input logic          stall,
  input logic          int_valid,
  input logic [IW-1:0] int_instr,
  input logic          fp_valid,
  input logic [IW-1:0] fp_instr
);
  function automatic logic fpw(input logic [IW-1:0] w);
    return (w[IW-1 -: 6] == 6'h13) ||
           (w[IW-1 -: 6] == 6'h11 && (w[IW-7 -: 5] == 5'h10 || w[IW-7 -: 5] == 5'h11));
  endfunction

  assert_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_tag == {1'b0, fpw(in_instr1), fpw(in_instr0), fpw(in_instr0) ^ fpw(in_instr1)});

  assert_fp_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fp_valid |-> fpw(fp_instr));

  assert_int_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int_valid |-> !fpw(int_instr));

  assert_split_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !stall) |-> (int_valid ^ fp_valid));

  assert_split_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !stall) |=> (stall || (int_valid ^ fp_valid)));

  assert_stall_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!int_valid && !fp_valid));
endmodule

bind dual_issue_pair dual_issue_pair_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_instr0(in_instr0), .in_instr1(in_instr1),
  .in_ready(in_ready), .fill_tag(fill_tag), .stall(stall),
  .int_valid(int_valid), .int_instr(int_instr),
  .fp_valid(fp_valid), .fp_instr(fp_instr)
);

// File: tb/dual_issue_pair_bench.sv
`timescale 1ns/1ps
module dual_issue_pair_bench;
  logic        clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, stall = 1'b0;
  logic [31:0] in_instr0 = '0, in_instr1 = '0;
  logic        in_ready, int_valid, fp_valid;
  logic [3:0]  fill_tag;
  logic [31:0] int_instr, fp_instr;
  int total = 0, bad = 0;
  logic [65:0] exp_q[$];

  always #4 clk = ~clk;

  dual_issue_pair u_dual_issue_pair (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr0(in_instr0),
    .in_instr1(in_instr1), .in_ready(in_ready), .fill_tag(fill_tag), .stall(stall),
    .int_valid(int_valid), .int_instr(int_instr), .fp_valid(fp_valid), .fp_instr(fp_instr));

  function automatic logic fp_of(input logic [31:0] w);
    return (w[31:26] == 6'h13) || (w[31:26] == 6'h11 && (w[25:21] == 5'h10 || w[25:21] == 5'h11));
  endfunction

  function automatic logic [31:0] mk(input int k, input logic [31:0] r);
    case (k)
      0: return {6'h11, 5'h10, r[20:0]};
      1: return {6'h11, 5'h11, r[20:0]};
      2: return {6'h13, r[25:0]};
      3: return {6'h11, 5'h04, r[20:0]};
      4: return {6'h31, r[25:0]};
      5: return {6'h09, r[25:0]};
      6: return {6'h04, r[25:0]};
      default: return {6'h00, r[25:0]};
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input logic [65:0] act, input logic [65:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic iv, input logic [31:0] a, input logic [31:0] b, input logic st);
    logic fa, fb, erdy, ok;
    logic [65:0] e, act;
    @(negedge clk);
    in_valid = iv; in_instr0 = a; in_instr1 = b; stall = st;
    #1;
    fa = fp_of(a); fb = fp_of(b);
    chk(fill_tag == {1'b0, fb, fa, fa ^ fb}, "R1/R2 tag", {62'd0, fill_tag}, {62'd0, 1'b0, fb, fa, fa ^ fb});
    erdy = (exp_q.size() == 0) || (exp_q.size() == 1 && !st);
    chk(in_ready == erdy, (exp_q.size() == 2) ? "R5 ready" : "R7 ready", {65'd0, in_ready}, {65'd0, erdy});
    act = {int_valid, int_instr, fp_valid, fp_instr};
    if (st) begin
      chk(!int_valid && !fp_valid, "R6 stall", act, 66'd0);
    end else if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      ok = (int_valid == e[65]) && (fp_valid == e[32]) &&
           (!e[65] || int_instr == e[64:33]) && (!e[32] || fp_instr == e[31:0]);
      chk(ok, (e[65] && e[32]) ? "R3 pair issue" : "R4 split issue", act, e);
    end else begin
      chk(!int_valid && !fp_valid, "R4 idle", act, 66'd0);
    end
    if (iv && in_ready) begin
      if (fa ^ fb) exp_q.push_back({1'b1, fa ? b : a, 1'b1, fa ? a : b});
      else begin
        exp_q.push_back({!fa, a, fa, a});
        exp_q.push_back({!fb, b, fb, b});
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    chk(!int_valid && !fp_valid && in_ready, "R8 reset", {63'd0, int_valid, fp_valid, in_ready}, 66'd1);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(!int_valid && !fp_valid && in_ready, "R8 after release", {63'd0, int_valid, fp_valid, in_ready}, 66'd1);
    // R1 classification corners
    step(0, mk(3, 32'h1), mk(4, 32'h2), 0);
    step(0, mk(2, 32'h3), mk(0, 32'h4), 0);
    // R3 swap: FP in slot1
    step(1, mk(5, 32'h11), mk(0, 32'h22), 0);
    // R3 FP in slot0 with FP load companion
    step(1, mk(2, 32'h33), mk(4, 32'h44), 0);
    // R4 two integer words, then two FP words
    step(1, mk(5, 32'h55), mk(6, 32'h66), 0);
    step(1, mk(1, 32'h77), mk(0, 32'h88), 0);
    step(1, mk(1, 32'h77), mk(0, 32'h88), 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    // R6 stall inside a split pair
    step(1, mk(7, 32'h99), mk(3, 32'haa), 0);
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    // R7 back-to-back pairable pairs
    for (int i = 0; i < 6; i++) step(1, mk(i % 3, i), mk(4 + (i % 4), i + 100), 0);
    // random
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, mk($urandom % 8, $urandom), mk($urandom % 8, $urandom), ($urandom % 5) == 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0);
    chk(exp_q.size() == 0, "R4 drained", {32'd0, 34'(exp_q.size())}, 66'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule